// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This block drains received frame data from a word-wide receive FIFO and stores it in memory buffers described by a ring of receive descriptors. Software prepares each descriptor (marking it active, giving a buffer length and a buffer address), programs the ring base address, and then sets the enable and request bits. The engine fetches a descriptor, fills its buffer from the FIFO, and writes the descriptor back: first the byte count, then the control word with the active bit cleared. Ownership thereby returns to software.

A frame longer than one buffer continues into the next descriptor. Only the first piece of a frame carries the first-of-frame flag, and only the piece in which the FIFO's end-of-frame word was stored carries the last-of-frame flag and the frame status. After every write-back the engine fetches the following descriptor at once, so it is ready before more data arrives. An inactive descriptor stops the engine and drops the request bit, and software restarts it by writing the request bit again.

Descriptor layout (four 32-bit words at pointer +0, +4, +8, +12): word 0 has active at bit 31, ring-end at bit 30, first-of-frame at bit 29, last-of-frame at bit 28 and status in bits 15:0. Word 1 holds the buffer length in bytes, a non-zero multiple of 4. Word 2 holds the buffer address. Word 3 receives the stored byte count. Registers: address 0 is control (bit 0 soft reset, write-only, reads 0; bit 1 enable), address 1 is the request bit (bit 0), and address 2 is the ring base address. Each FIFO word counts as 4 bytes.

Top module: `rxdesc_dma`

## Requirements
- R1: Writing 1 to control bit 0 clears enable, request and ring base (all three registers read 0 afterwards), returns the engine to idle with its ring pointer forgotten, and leaves no memory request from the next cycle on.
- R2: With enable at 0, or with request at 0 while idle, the engine issues no memory request and pops nothing from the FIFO.
- R3: On start, the engine reads descriptor words 0, 1 and 2 at ring base +0, +4 and +8 in that order, before any buffer write. The first descriptor after reset or soft reset is taken at the ring base.
- R4: FIFO words are written in arrival order to buffer address +0, +4, +8 and so on. Exactly one FIFO word is popped for each accepted buffer write.
- R5: When a buffer is finished, the engine writes word 3 (byte count) and then word 0. Word 0 is written as active 0, with ring-end kept at bit 30, first-of-frame at bit 29, last-of-frame at bit 28, and in bits 15:0 the FIFO status of the end-of-frame word (0 when the piece is not the last).
- R6: When the byte count reaches the buffer length before end-of-frame, that descriptor is written back with last-of-frame 0. The frame then continues in the next descriptor, which is written with first-of-frame 0.
- R7: After the write-back of a frame's last piece, the next descriptor is read at once, even with the FIFO empty.
- R8: A fetched descriptor whose word 0 bit 31 is 0 is neither filled nor written back, and the request bit reads 0 afterwards. Writing request 1 makes the engine fetch that same descriptor again.
- R9: After a descriptor with ring-end set, the next descriptor is fetched at the ring base. Otherwise it is fetched at pointer +16.
- R10: A memory request that is not yet accepted keeps its address, direction and write data unchanged until mem_ready is high.
- R11: An end-of-frame word that also fills the buffer ends the frame in that descriptor: last-of-frame is 1 and the byte count equals the length. The next frame starts with first-of-frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 request, 2 ring base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_eof | input | 1 | Head word ends the frame |
| fifo_status | input | STAT_W | Frame status carried with the head word |
| fifo_pop | output | 1 | Consume the head word |

## Verification
Register effects, including the request drop after a stall and the clearing by soft reset, show on the combinational read port in the cycle after the write or after the fetch that caused them. The bench samples them half a cycle after that edge. Memory-side results depend on how often mem_ready stalls, so the bench does not count cycles for them. It logs every accepted transaction in order and checks positions in that log (descriptor reads, buffer writes, the two write-backs, the prefetch). It checks memory contents only after a window several times longer than the worst-case transaction count. Request hold under back-pressure is watched on every cycle in which mem_ready is low.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_RD2,
        S_MOVE,
        S_WB3,
        S_WB0
    } eng_state_e;

    localparam int unsigned BIT_ACT  = 31;
    localparam int unsigned BIT_END  = 30;
    localparam int unsigned WORD_B   = 4;
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_REQ  = 1;
    localparam int unsigned REG_BASE = 2;
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_clr,
    output logic              srst,
    output logic              en,
    output logic              req,
    output logic [ADDR_W-1:0] base
);
    import rxdma_pkg::*;

    typedef struct packed {
        logic              en;
        logic              req;
        logic [ADDR_W-1:0] base;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ctrl, wr_req, wr_base;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == 2'(REG_CTRL));
        wr_req  = reg_we && (reg_addr == 2'(REG_REQ));
        wr_base = reg_we && (reg_addr == 2'(REG_BASE));
        srst    = wr_ctrl && reg_wdata[0];
        r_d     = r_q;
        if (wr_ctrl) begin
            r_d.en = reg_wdata[1];
        end
        if (wr_req) begin
            r_d.req = reg_wdata[0];
        end else if (req_clr) begin
            r_d.req = 1'b0;
        end
        if (wr_base) begin
            r_d.base = reg_wdata[ADDR_W-1:0];
        end
        if (srst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            2'(REG_CTRL): reg_rdata = {30'b0, r_q.en, 1'b0};
            2'(REG_REQ):  reg_rdata = {31'b0, r_q.req};
            2'(REG_BASE): reg_rdata = 32'(r_q.base);
            default:      reg_rdata = 32'b0;
        endcase
    end

    assign en   = r_q.en;
    assign req  = r_q.req;
    assign base = r_q.base;
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              en,
    input  logic              req,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              fifo_valid,
    input  logic [31:0]       fifo_data,
    input  logic              fifo_eof,
    input  logic [STAT_W-1:0] fifo_status,
    output logic              fifo_pop,
    output logic              req_clr
);
    import rxdma_pkg::*;

    localparam logic [ADDR_W-1:0] OFS_W1  = ADDR_W'(WORD_B);
    localparam logic [ADDR_W-1:0] OFS_W2  = ADDR_W'(2 * WORD_B);
    localparam logic [ADDR_W-1:0] OFS_W3  = ADDR_W'(3 * WORD_B);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(DESC_WORDS * WORD_B);
    localparam logic [LEN_W-1:0]  CNT_INC = LEN_W'(WORD_B);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic              ptr_ok;
        logic [ADDR_W-1:0] buf_a;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              de;
        logic              fs;
        logic              ls;
        logic              in_frame;
        logic [STAT_W-1:0] stat;
    } eng_t;

    eng_t             q, d;
    logic             go;
    logic             took;
    logic [LEN_W-1:0] cnt_nx;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = 32'b0;
        fifo_pop  = 1'b0;
        req_clr   = 1'b0;
        go        = en && fifo_valid && (q.in_frame || req);
        took      = en && mem_ready;
        cnt_nx    = q.cnt + CNT_INC;

        case (q.st)
            S_IDLE: begin
                if (en && req) begin
                    d.st = S_RD0;
                    if (!q.ptr_ok) begin
                        d.ptr    = base;
                        d.ptr_ok = 1'b1;
                    end
                end
            end
            S_RD0: begin
                mem_req  = en;
                mem_addr = q.ptr;
                if (took) begin
                    if (!mem_rdata[BIT_ACT]) begin
                        req_clr = 1'b1;
                        d.st    = S_IDLE;
                    end else begin
                        d.de = mem_rdata[BIT_END];
                        d.st = S_RD1;
                    end
                end
            end
            S_RD1: begin
                mem_req  = en;
                mem_addr = q.ptr + OFS_W1;
                if (took) begin
                    d.len = mem_rdata[LEN_W-1:0];
                    d.st  = S_RD2;
                end
            end
            S_RD2: begin
                mem_req  = en;
                mem_addr = q.ptr + OFS_W2;
                if (took) begin
                    d.buf_a = mem_rdata[ADDR_W-1:0];
                    d.cnt   = '0;
                    d.fs    = !q.in_frame;
                    d.ls    = 1'b0;
                    d.stat  = '0;
                    d.st    = S_MOVE;
                end
            end
            S_MOVE: begin
                mem_req   = go;
                mem_we    = 1'b1;
                mem_addr  = q.buf_a + ADDR_W'(q.cnt);
                mem_wdata = fifo_data;
                if (go && mem_ready) begin
                    fifo_pop = 1'b1;
                    d.cnt    = cnt_nx;
                    if (fifo_eof) begin
                        d.ls       = 1'b1;
                        d.stat     = fifo_status;
                        d.in_frame = 1'b0;
                        d.st       = S_WB3;
                    end else begin
                        d.in_frame = 1'b1;
                        if (cnt_nx >= q.len) begin
                            d.st = S_WB3;
                        end
                    end
                end
            end
            S_WB3: begin
                mem_req   = en;
                mem_we    = 1'b1;
                mem_addr  = q.ptr + OFS_W3;
                mem_wdata = 32'(q.cnt);
                if (took) begin
                    d.st = S_WB0;
                end
            end
            S_WB0: begin
                mem_req   = en;
                mem_we    = 1'b1;
                mem_addr  = q.ptr;
                mem_wdata = {1'b0, q.de, q.fs, q.ls, 12'b0, 16'(q.stat)};
                if (took) begin
                    d.ptr = q.de ? base : (q.ptr + STRIDE);
                    d.st  = S_RD0;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (srst) begin
            d       = '0;
            d.st    = S_IDLE;
            mem_req = 1'b0;
            fifo_pop = 1'b0;
            req_clr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              fifo_valid,
    input  logic [31:0]       fifo_data,
    input  logic              fifo_eof,
    input  logic [STAT_W-1:0] fifo_status,
    output logic              fifo_pop
);
    logic              ctl_srst;
    logic              ctl_en;
    logic              ctl_req;
    logic              req_clr;
    logic [ADDR_W-1:0] ring_base;

    rxdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_clr   (req_clr),
        .srst      (ctl_srst),
        .en        (ctl_en),
        .req       (ctl_req),
        .base      (ring_base)
    );

    rxdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (ctl_srst),
        .en          (ctl_en),
        .req         (ctl_req),
        .base        (ring_base),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .fifo_valid  (fifo_valid),
        .fifo_data   (fifo_data),
        .fifo_eof    (fifo_eof),
        .fifo_status (fifo_status),
        .fifo_pop    (fifo_pop),
        .req_clr     (req_clr)
    );
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst,
    input logic              en,
    input logic              req,
    input logic              req_clr,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              fifo_pop
);
    // R1: soft reset leaves registers cleared and the memory port quiet
    a_r1_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!en && !req && !mem_req));

    // R2: a disabled engine never touches memory
    a_r2_off_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!mem_req && !fifo_pop));

    // R4: a FIFO word leaves only with an accepted buffer write
    a_r4_pop_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (mem_req && mem_we && mem_ready));

    // R8: an inactive descriptor drops the request bit
    a_r8_stall_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr && !srst && !(reg_we && reg_addr == 2'd1)) |=> !req);

    // R10: a pending request holds until accepted
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !reg_we) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind rxdesc_dma rxdesc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (ctl_srst),
    .en        (ctl_en),
    .req       (ctl_req),
    .req_clr   (req_clr),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fifo_pop  (fifo_pop)
);

// File: tb/sim_rxdesc_dma.sv
`timescale 1ns/1ps
module sim_rxdesc_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        fifo_valid, fifo_eof, fifo_pop;
    logic [31:0] fifo_data;
    logic [15:0] fifo_status;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [0:511];
    logic [31:0] lg_addr [0:127];
    logic        lg_we   [0:127];
    int          lg_n = 0;
    logic        bk_we = 1'b0;
    logic [8:0]  bk_idx = 9'd0;
    logic [31:0] bk_data = 32'd0;

    logic [31:0] fq_d [0:63];
    logic        fq_e [0:63];
    logic [15:0] fq_s [0:63];
    int          f_wr = 0;
    int          f_rd = 0;
    int          rdy_cnt = 0;
    int          hold_err = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = 32'd0;

    always #10 clk = ~clk;

    rxdesc_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .fifo_eof(fifo_eof), .fifo_status(fifo_status),
        .fifo_pop(fifo_pop)
    );

    assign mem_rdata   = mem[mem_addr[10:2]];
    assign fifo_valid  = (f_rd != f_wr);
    assign fifo_data   = fq_d[f_rd[5:0]];
    assign fifo_eof    = fq_e[f_rd[5:0]];
    assign fifo_status = fq_s[f_rd[5:0]];

    always @(posedge clk) begin
        if (bk_we) begin
            mem[bk_idx] <= bk_data;
        end else if (mem_req && mem_ready && mem_we) begin
            mem[mem_addr[10:2]] <= mem_wdata;
        end
        if (mem_req && mem_ready) begin
            if (lg_n < 128) begin
                lg_addr[lg_n] <= mem_addr;
                lg_we[lg_n]   <= mem_we;
            end
            lg_n <= lg_n + 1;
        end
        if (fifo_pop) f_rd <= f_rd + 1;
        if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
        prev_wait <= mem_req && !mem_ready;
        prev_addr <= mem_addr;
    end

    always @(negedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        mem_ready <= (rdy_cnt % 3) != 2;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic bk_write(input logic [31:0] byte_a, input logic [31:0] v);
        @(negedge clk);
        bk_we = 1'b1; bk_idx = byte_a[10:2]; bk_data = v;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] v, input logic e, input logic [15:0] s);
        fq_d[f_wr % 64] = v; fq_e[f_wr % 64] = e; fq_s[f_wr % 64] = s;
        f_wr = f_wr + 1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(2'd0, v); check("R1 ctrl after reset", v, 32'd0);
        reg_rd(2'd1, v); check("R1 request after reset", v, 32'd0);
        check("R1 no request after reset", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        int n0;
        bk_write(32'h100, 32'h8000_0000); bk_write(32'h104, 32'd32); bk_write(32'h108, 32'h200);
        bk_write(32'h110, 32'h8000_0000); bk_write(32'h114, 32'd32); bk_write(32'h118, 32'h300);
        bk_write(32'h120, 32'hC000_0000); bk_write(32'h124, 32'd32); bk_write(32'h128, 32'h340);
        reg_wr(2'd2, 32'h100);
        n0 = lg_n;
        reg_wr(2'd1, 32'd1);
        wait_cyc(30);
        check("R2 request without enable stays idle", 32'(lg_n - n0), 32'd0);
        reg_wr(2'd1, 32'd0);
        reg_wr(2'd0, 32'd2);
        wait_cyc(30);
        check("R2 enable without request stays idle", 32'(lg_n - n0), 32'd0);
        reg_rd(2'd0, v); check("R2 enable reads back", v, 32'd2);
    endtask

    task automatic t_frame1();
        push(32'hA0A0_0001, 1'b0, 16'h0);
        push(32'hA0A0_0002, 1'b0, 16'h0);
        push(32'hA0A0_0003, 1'b1, 16'h5A5A);
        reg_wr(2'd1, 32'd1);
        wait_cyc(80);
        check("R3 first read at base", lg_addr[0], 32'h100);
        check("R3 first access is read", {31'b0, lg_we[0]}, 32'd0);
        check("R3 second read word1", lg_addr[1], 32'h104);
        check("R3 third read word2", lg_addr[2], 32'h108);
        check("R4 buffer word 0", mem[32'h200 >> 2], 32'hA0A0_0001);
        check("R4 buffer word 2", mem[32'h208 >> 2], 32'hA0A0_0003);
        check("R5 count write first", lg_addr[6], 32'h10C);
        check("R5 byte count", mem[32'h10C >> 2], 32'd12);
        check("R5 control write second", lg_addr[7], 32'h100);
        check("R5 control word", mem[32'h100 >> 2], 32'h3000_5A5A);
        check("R7 prefetch next descriptor", lg_addr[8], 32'h110);
        check("R7 prefetch is read", {31'b0, lg_we[8]}, 32'd0);
    endtask

    task automatic t_span();
        logic [31:0] v;
        for (int i = 0; i < 10; i++) push(32'hB000_0000 + 32'(i), i == 9, (i == 9) ? 16'h1234 : 16'h0);
        wait_cyc(150);
        check("R6 first piece count", mem[32'h11C >> 2], 32'd32);
        check("R6 first piece control", mem[32'h110 >> 2], 32'h2000_0000);
        check("R6 last of first buffer", mem[32'h31C >> 2], 32'hB000_0007);
        check("R6 continues in next buffer", mem[32'h340 >> 2], 32'hB000_0008);
        check("R6 second piece count", mem[32'h12C >> 2], 32'd8);
        check("R5 ring-end kept, last flag", mem[32'h120 >> 2], 32'h5000_1234);
        check("R9 wrap to base", lg_addr[lg_n - 1], 32'h100);
        reg_rd(2'd1, v); check("R8 request dropped on inactive", v, 32'd0);
        check("R8 inactive descriptor untouched", mem[32'h100 >> 2], 32'h3000_5A5A);
    endtask

    task automatic t_resume();
        logic [31:0] v;
        bk_write(32'h100, 32'h8000_0000); bk_write(32'h104, 32'd8); bk_write(32'h108, 32'h380);
        push(32'hC000_0001, 1'b0, 16'h0);
        push(32'hC000_0002, 1'b1, 16'h00C3);
        reg_wr(2'd1, 32'd1);
        wait_cyc(80);
        check("R8 resumed fill", mem[32'h384 >> 2], 32'hC000_0002);
        check("R11 exact fill count", mem[32'h10C >> 2], 32'd8);
        check("R11 exact fill flags", mem[32'h100 >> 2], 32'h3000_00C3);
        check("R9 no wrap steps by 16", lg_addr[lg_n - 1], 32'h110);
        reg_rd(2'd1, v); check("R8 stalls again", v, 32'd0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        int n0;
        reg_wr(2'd1, 32'd1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd3;
        @(negedge clk);
        reg_we = 1'b0;
        n0 = lg_n;
        check("R1 no request after soft reset", {31'b0, mem_req}, 32'd0);
        reg_rd(2'd0, v); check("R1 enable cleared", v, 32'd0);
        reg_rd(2'd1, v); check("R1 request cleared", v, 32'd0);
        reg_rd(2'd2, v); check("R1 base cleared", v, 32'd0);
        wait_cyc(20);
        check("R1 stays quiet", 32'(lg_n - n0), 32'd0);
        check("R10 requests held under back-pressure", 32'(hold_err), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'd0;
        for (int i = 0; i < 64; i++) begin fq_d[i] = 0; fq_e[i] = 0; fq_s[i] = 0; end
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_idle();
        t_frame1();
        t_span();
        t_resume();
        t_srst();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #4000000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule